// File: doc/BRIEF.md
# Atomic Bit Read-Modify-Write Unit

This unit sits beside a CPU pipeline's memory stage. It executes single-bit atomic operations on a memory word. Each operation carries an address, a bit position and an operation code, and it clears, sets or toggles the selected bit. The address selects one of two regions. One is a small internal RAM that the unit owns, fronted by a one-entry write buffer. The other is a slower system-bus region, reached through a plain request/ready handshake.

The pipeline offers one instruction per cycle. Each instruction is tagged as non-memory, load, store or read-modify-write. The unit answers with a combinational `stall` that holds the instruction in place. A bus-region operation keeps running in the background for at least three more cycles, and non-memory instructions keep flowing during that time. Any memory instruction that arrives in that window is held until the bus operation has finished, so no other access can come between its read and its write. Plain loads and stores to the internal RAM are serviced here, so the write buffer always reflects real traffic. A `done` pulse marks the last cycle of every operation. A latency register reports how many cycles the most recent operation took.

Top module: `bitrmw_top`

## Requirements
- R1: The operation code `ins_op` selects the new word: 0 forces bit `ins_bit` to 0, 1 forces it to 1, 2 inverts it, and 3 writes the word back unchanged. All other bits keep their read value.
- R2: An address whose bits above the low `IRAM_AW` bits match `IRAM_BASE` targets the internal RAM at word index `addr[IRAM_AW-1:0]`. Every other address goes to the bus path. With the defaults, word address 0x3F is internal RAM and 0x40 is bus.
- R3: An internal-RAM operation presented while the write buffer is empty and no bus operation is running is accepted without stall. `done` is high in that same cycle, and the recorded latency is 1.
- R4: The write buffer is non-empty in the cycle after an accepted internal-RAM store or internal-RAM read-modify-write. An internal-RAM operation presented then is stalled for exactly one cycle, and its recorded latency is 2.
- R5: A bus-region operation reads the word over the bus, modifies it, and writes it back. With no wait states, `done` is high in the fourth cycle counting the accepting cycle, and the recorded latency is 4.
- R6: A memory instruction (`ins_cls` 1, 2 or 3) presented after n non-memory instructions that follow an accepted bus-region operation is stalled 3−n cycles for n below 3. For n of 3 or more it is not stalled.
- R7: An instruction with `ins_cls` 0 (non-memory) is never stalled, even while a bus-region operation runs.
- R8: Each cycle that `bus_ready` is low while `bus_req` is high lengthens the bus-region operation, its latency and the stall of waiting memory instructions by one cycle. The request, address and direction are held while waiting.
- R9: `lat_last` is updated at the clock edge that ends each operation's `done` cycle, and it holds that operation's latency until the next operation completes.
- R10: A load to the internal RAM raises `ld_valid` one cycle after acceptance, with the current word, including a value still in the write buffer. A load outside that region leaves `ld_valid` low.
- R11: After reset, `stall`, `done`, `bus_req`, `ld_valid` and `lat_last` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction presented this cycle |
| ins_cls | input | 2 | 0 non-memory, 1 load, 2 store, 3 read-modify-write |
| ins_op | input | 2 | Bit operation code |
| ins_addr | input | ADDR_W | Word address |
| ins_bit | input | BIT_W | Selected bit position |
| ins_wdata | input | DATA_W | Store data |
| stall | output | 1 | Hold the presented instruction |
| done | output | 1 | Last cycle of a read-modify-write |
| lat_last | output | LAT_W | Latency of the most recent operation |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | DATA_W | Load data |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ready | input | 1 | Bus completes the current transfer |

## Verification
`stall` and `done` are combinational. The bench drives each instruction just after a falling edge and reads both one time step later, in the same cycle. `lat_last` and the load data come out of registers, so the bench reads them at the falling edge that follows the accepting or completing edge. It never reads them in the presenting cycle. The model tracks how many bus cycles remain, including the wait states the bench's own bus responder inserts, so every stall length is predicted before the instruction is driven. A bus operation's latency is checked at the first instruction boundary after its `done` cycle has passed.

// File: rtl/bitrmw_pkg.sv
package bitrmw_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_RMW   = 2'd3
  } ins_cls_e;

  typedef enum logic [1:0] {
    BOP_CLR  = 2'd0,
    BOP_SET  = 2'd1,
    BOP_FLIP = 2'd2,
    BOP_KEEP = 2'd3
  } bitop_e;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_RD   = 2'd1,
    BS_MOD  = 2'd2,
    BS_WR   = 2'd3
  } bus_st_e;

endpackage

// File: rtl/bitrmw_bitop.sv
module bitrmw_bitop #(
  parameter int DW = 32,
  localparam int BW = $clog2(DW)
) (
  input  logic [DW-1:0]       word_i,
  input  bitrmw_pkg::bitop_e  op_i,
  input  logic [BW-1:0]       pos_i,
  output logic [DW-1:0]       word_o
);
  import bitrmw_pkg::*;

  // One small mux per bit; only the addressed lane may change.
  for (genvar i = 0; i < DW; i++) begin : g_lane
    logic hit;
    assign hit = (pos_i == BW'(i));
    assign word_o[i] = !hit                ? word_i[i] :
                       (op_i == BOP_CLR)  ? 1'b0      :
                       (op_i == BOP_SET)  ? 1'b1      :
                       (op_i == BOP_FLIP) ? ~word_i[i] : word_i[i];
  end

  always_comb begin
    if (op_i == BOP_FLIP) begin
      assert_flip_one_R1: assert ($countones(word_o ^ word_i) == 1);
    end else begin
      assert_at_most_one_R1: assert ($countones(word_o ^ word_i) <= 1);
    end
  end

endmodule

// File: rtl/bitrmw_decode.sv
module bitrmw_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          IRAM_AW   = 6,
  parameter logic [31:0] IRAM_BASE = 32'h0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               is_iram_o,
  output logic [IRAM_AW-1:0] idx_o
);
  localparam int HI_W = ADDR_W - IRAM_AW;
  localparam logic [HI_W-1:0] BASE_HI = IRAM_BASE[ADDR_W-1:IRAM_AW];

  assign is_iram_o = (addr_i[ADDR_W-1:IRAM_AW] == BASE_HI);
  assign idx_o     = addr_i[IRAM_AW-1:0];

endmodule

// File: rtl/bitrmw_iram.sv
module bitrmw_iram #(
  parameter int DW = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_en,
  input  logic [AW-1:0] st_idx,
  input  logic [DW-1:0] st_data,
  input  logic [AW-1:0] rd_idx,
  input  logic          ld_en,
  output logic          wb_valid,
  output logic [DW-1:0] rd_data,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wb_idx;
  logic [DW-1:0] wb_data;

  // Array port: drains the buffer; no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (wb_valid) mem[wb_idx] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= st_en;
      if (st_en) begin
        wb_idx  <= st_idx;
        wb_data <= st_data;
      end
    end
  end

  assign rd_data = (wb_valid && wb_idx == rd_idx) ? wb_data : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_en;
      if (ld_en) ld_data <= rd_data;
    end
  end

  assert_drain_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !st_en) |=> !wb_valid);

  assert_ld_next_R10: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> ld_valid);

endmodule

// File: rtl/bitrmw_bus_seq.sv
module bitrmw_bus_seq #(
  parameter int ADDR_W = 32,
  parameter int DW     = 32,
  parameter int LAT_W  = 8,
  localparam int BW    = $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  bitrmw_pkg::bitop_e start_op,
  input  logic [BW-1:0]      start_bit,
  output logic               busy,
  output logic               done,
  output logic [LAT_W-1:0]   lat,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_ready
);
  import bitrmw_pkg::*;

  bus_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  bitop_e            op_q;
  logic [BW-1:0]     bit_q;
  logic [DW-1:0]     data_q;
  logic [DW-1:0]     data_mod;
  logic [LAT_W-1:0]  cnt_q;

  bitrmw_bitop #(.DW(DW)) u_mod (
    .word_i(data_q), .op_i(op_q), .pos_i(bit_q), .word_o(data_mod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= BS_IDLE;
      addr_q <= '0;
      op_q   <= BOP_KEEP;
      bit_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        BS_IDLE: if (start) begin
          st_q   <= BS_RD;
          addr_q <= start_addr;
          op_q   <= start_op;
          bit_q  <= start_bit;
          cnt_q  <= LAT_W'(1);
        end
        BS_RD: begin
          cnt_q <= cnt_q + LAT_W'(1);
          if (bus_ready) begin
            data_q <= bus_rdata;
            st_q   <= BS_MOD;
          end
        end
        BS_MOD: begin
          cnt_q  <= cnt_q + LAT_W'(1);
          data_q <= data_mod;
          st_q   <= BS_WR;
        end
        BS_WR: begin
          if (bus_ready) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + LAT_W'(1);
          end
        end
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != BS_IDLE);
  assign done      = (st_q == BS_WR) && bus_ready;
  assign lat       = cnt_q + LAT_W'(1);
  assign bus_req   = (st_q == BS_RD) || (st_q == BS_WR);
  assign bus_we    = (st_q == BS_WR);
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;

  assert_start_reads_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (bus_req && !bus_we && bus_addr == $past(start_addr)));

  assert_read_gap_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_ready) |=> !bus_req ##1 (bus_req && bus_we));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

endmodule

// File: rtl/bitrmw_top.sv
module bitrmw_top #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          IRAM_AW   = 6,
  parameter logic [31:0] IRAM_BASE = 32'h0,
  parameter int          LAT_W     = 8,
  localparam int         BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [1:0]        ins_cls,
  input  logic [1:0]        ins_op,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [BIT_W-1:0]  ins_bit,
  input  logic [DATA_W-1:0] ins_wdata,
  output logic              stall,
  output logic              done,
  output logic [LAT_W-1:0]  lat_last,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  import bitrmw_pkg::*;

  ins_cls_e           cls;
  bitop_e             op;
  logic               is_iram;
  logic [IRAM_AW-1:0] idx;
  logic               is_mem, acc;
  logic               bus_busy, bus_done, bus_start;
  logic [LAT_W-1:0]   bus_lat;
  logic               wb_valid, iram_wait, iram_done;
  logic               st_en, ld_en;
  logic [DATA_W-1:0]  st_data, rd_data, rmw_new;
  logic [LAT_W-1:0]   cyc_i;

  assign cls = ins_cls_e'(ins_cls);
  assign op  = bitop_e'(ins_op);

  bitrmw_decode #(.ADDR_W(ADDR_W), .IRAM_AW(IRAM_AW), .IRAM_BASE(IRAM_BASE)) u_dec (
    .addr_i(ins_addr), .is_iram_o(is_iram), .idx_o(idx)
  );

  // Hazard resolution: a running bus operation locks out every memory
  // instruction; a full write buffer costs an internal RMW one drain cycle.
  assign is_mem    = ins_valid && (cls != CLS_ALU);
  assign iram_wait = ins_valid && (cls == CLS_RMW) && is_iram && !bus_busy && wb_valid;
  assign stall     = is_mem && (bus_busy || iram_wait);
  assign acc       = ins_valid && !stall;
  assign iram_done = acc && (cls == CLS_RMW) && is_iram;
  assign bus_start = acc && (cls == CLS_RMW) && !is_iram;
  assign st_en     = (acc && (cls == CLS_STORE) && is_iram) || iram_done;
  assign st_data   = iram_done ? rmw_new : ins_wdata;
  assign ld_en     = acc && (cls == CLS_LOAD) && is_iram;
  assign done      = iram_done || bus_done;

  bitrmw_iram #(.DW(DATA_W), .AW(IRAM_AW)) u_iram (
    .clk(clk), .rst(rst),
    .st_en(st_en), .st_idx(idx), .st_data(st_data),
    .rd_idx(idx), .ld_en(ld_en),
    .wb_valid(wb_valid), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  bitrmw_bitop #(.DW(DATA_W)) u_iram_mod (
    .word_i(rd_data), .op_i(op), .pos_i(ins_bit), .word_o(rmw_new)
  );

  bitrmw_bus_seq #(.ADDR_W(ADDR_W), .DW(DATA_W), .LAT_W(LAT_W)) u_bus (
    .clk(clk), .rst(rst),
    .start(bus_start), .start_addr(ins_addr), .start_op(op), .start_bit(ins_bit),
    .busy(bus_busy), .done(bus_done), .lat(bus_lat),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // Latency bookkeeping for internal-RAM operations (drain cycles only).
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_i    <= '0;
      lat_last <= '0;
    end else begin
      if (iram_done)      cyc_i <= '0;
      else if (iram_wait) cyc_i <= cyc_i + LAT_W'(1);
      if (bus_done)       lat_last <= bus_lat;
      else if (iram_done) lat_last <= cyc_i + LAT_W'(1);
    end
  end

  assert_alu_free_R7: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_cls == 2'd0) |-> !stall);

  assert_bus_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_cls != 2'd0 && bus_req) |-> stall);

  assert_lat_set_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (lat_last != '0));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_ready) |-> done);

endmodule

// File: tb/tb_bitrmw_top.sv
module tb_bitrmw_top;
  localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_RMW = 2'd3;
  localparam logic [1:0] O_CLR = 2'd0, O_SET = 2'd1, O_FLIP = 2'd2, O_KEEP = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_cls = C_ALU, ins_op = O_CLR;
  logic [31:0] ins_addr = '0, ins_wdata = '0;
  logic [4:0]  ins_bit = '0;
  logic        stall, done, ld_valid, bus_req, bus_we;
  logic [7:0]  lat_last;
  logic [31:0] ld_data, bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;

  logic [31:0] dev_mem [16];
  logic [31:0] eb [16];
  logic [31:0] im [64];
  int ws_left = 0;
  int n_chk = 0, n_fail = 0;
  int rem = 0, pend_lat = 0, pend_w = 0;
  bit pend = 0, prev_wb = 0, finished = 0;

  always #5 clk = ~clk;

  bitrmw_top dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_cls(ins_cls), .ins_op(ins_op),
    .ins_addr(ins_addr), .ins_bit(ins_bit), .ins_wdata(ins_wdata),
    .stall(stall), .done(done), .lat_last(lat_last), .ld_valid(ld_valid), .ld_data(ld_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // Bus device model with a programmable number of wait states.
  assign bus_rdata = dev_mem[bus_addr[3:0]];
  always @(posedge clk) if (bus_req && bus_we && bus_ready) dev_mem[bus_addr[3:0]] <= bus_wdata;
  always @(negedge clk) begin
    if (bus_req && ws_left > 0) begin bus_ready = 1'b0; ws_left = ws_left - 1; end
    else bus_ready = 1'b1;
  end

  function automatic logic [31:0] bitf(input logic [31:0] w, input logic [1:0] o, input logic [4:0] b);
    logic [31:0] m = 32'd1 << b;
    case (o)
      O_CLR:   return w & ~m;
      O_SET:   return w | m;
      O_FLIP:  return w ^ m;
      default: return w;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] o, input logic [31:0] a,
                      input logic [4:0] b, input logic [31:0] d, input int w,
                      output int st, output bit dn);
    ins_valid = 1'b1; ins_cls = c; ins_op = o; ins_addr = a; ins_bit = b; ins_wdata = d;
    st = 0; dn = 0;
    forever begin
      #1;
      if (!stall) begin
        dn = done;
        if (c == C_RMW && a[31:6] != 26'd0) ws_left = w;
        break;
      end
      st++;
      if (st > 100) begin check(0, "stall bound", st, 0); break; end
      @(negedge clk);
    end
    @(negedge clk);
    ins_valid = 1'b0; ins_cls = C_ALU;
  endtask

  task automatic do_ins(input logic [1:0] c, input logic [1:0] o, input logic [31:0] a,
                        input logic [4:0] b, input logic [31:0] d, input int w);
    bit is_i, wb_st, dn;
    int exp_st, st, cyc;
    string tag;
    is_i = (a[31:6] == 26'd0);
    exp_st = 0; wb_st = 0;
    if (c != C_ALU) begin
      if (rem > 0) exp_st = rem;
      else if (c == C_RMW && is_i && prev_wb) begin exp_st = 1; wb_st = 1; end
    end
    if (c == C_ALU)              tag = "R7 stall";
    else if (rem > 0)            tag = (pend_w > 0) ? "R8 stall" : "R6 stall";
    else if (wb_st)              tag = "R4 stall";
    else if (c == C_RMW && is_i) tag = "R3 stall";
    else                         tag = "R6 stall";
    step(c, o, a, b, d, w, st, dn);
    check(st == exp_st, tag, st, exp_st);
    cyc = st + 1;
    if (pend && rem <= cyc && !(c == C_RMW && is_i)) begin
      check(lat_last == pend_lat, (pend_w > 0) ? "R8 R9 latency" : "R5 R9 latency", lat_last, pend_lat);
      pend = 0;
    end
    if (c == C_RMW && is_i) begin
      pend = 0;
      check(dn, "R3 done", dn, 1);
      check(lat_last == (wb_st ? 2 : 1), wb_st ? "R4 R9 latency" : "R3 R9 latency", lat_last, wb_st ? 2 : 1);
      im[a[5:0]] = bitf(im[a[5:0]], o, b);
    end
    rem = (rem > cyc) ? rem - cyc : 0;
    if (c == C_RMW && !is_i) begin
      check(!dn, "R5 done early", dn, 0);
      rem = 3 + w; pend = 1; pend_lat = 4 + w; pend_w = w;
      eb[a[3:0]] = bitf(eb[a[3:0]], o, b);
    end
    if (c == C_ST && is_i) im[a[5:0]] = d;
    if (c == C_LD) begin
      if (is_i) check(ld_valid && ld_data == im[a[5:0]], "R10 load", ld_data, im[a[5:0]]);
      else      check(!ld_valid, "R10 bus load", ld_valid, 0);
    end
    prev_wb = is_i && (c == C_ST || c == C_RMW);
  endtask

  task automatic alu(input int n);
    for (int i = 0; i < n; i++) do_ins(C_ALU, O_CLR, 32'h0, 5'd0, 32'h0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin dev_mem[i] = $urandom; eb[i] = dev_mem[i]; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!stall && !done && !bus_req && !ld_valid && lat_last == 0, "R11 reset", {stall, done, bus_req, ld_valid}, 0);
    @(negedge clk);

    // Fill internal RAM; each store refills the buffer.
    for (int i = 0; i < 64; i++) do_ins(C_ST, O_CLR, 32'(i), 5'd0, $urandom, 0);

    // R1: explicit bit results, bit 31 and bit 0, and the no-change code.
    do_ins(C_ST, O_CLR, 32'd5, 5'd0, 32'h0000_0000, 0);
    alu(1);
    do_ins(C_RMW, O_SET, 32'd5, 5'd31, 32'h0, 0);
    do_ins(C_LD, O_CLR, 32'd5, 5'd0, 32'h0, 0);
    check(ld_data == 32'h8000_0000, "R1 set bit31", ld_data, 32'h8000_0000);
    do_ins(C_RMW, O_FLIP, 32'd5, 5'd0, 32'h0, 0);
    do_ins(C_LD, O_CLR, 32'd5, 5'd0, 32'h0, 0);
    check(ld_data == 32'h8000_0001, "R1 flip bit0", ld_data, 32'h8000_0001);
    do_ins(C_RMW, O_CLR, 32'd5, 5'd31, 32'h0, 0);
    do_ins(C_RMW, O_KEEP, 32'd5, 5'd0, 32'h0, 0);
    do_ins(C_LD, O_CLR, 32'd5, 5'd0, 32'h0, 0);
    check(ld_data == 32'h0000_0001, "R1 clear and keep", ld_data, 32'h0000_0001);

    // R10: load right after a store forwards the buffered value.
    do_ins(C_ST, O_CLR, 32'd9, 5'd0, 32'hCAFE_0009, 0);
    do_ins(C_LD, O_CLR, 32'd9, 5'd0, 32'h0, 0);

    // R2: region boundary.
    alu(1);
    do_ins(C_RMW, O_SET, 32'h0000_003F, 5'd3, 32'h0, 0);
    #1 check(!bus_req, "R2 internal boundary", bus_req, 0);
    alu(1);
    do_ins(C_RMW, O_SET, 32'h0000_0040, 5'd3, 32'h0, 0);
    #1 check(bus_req, "R2 bus boundary", bus_req, 1);

    // R6: distances 0..3 between a bus operation and the next memory access.
    for (int n = 0; n < 4; n++) begin
      alu(4);
      do_ins(C_RMW, O_FLIP, 32'h8000_0003, 5'(n), 32'h0, 0);
      alu(n);
      do_ins(C_LD, O_CLR, 32'h8000_0003, 5'd0, 32'h0, 0);
    end
    alu(4);
    do_ins(C_RMW, O_SET, 32'h8000_0001, 5'd7, 32'h0, 0);
    do_ins(C_RMW, O_CLR, 32'h8000_0002, 5'd1, 32'h0, 0);
    do_ins(C_RMW, O_SET, 32'd12, 5'd2, 32'h0, 0);

    // R8: wait states lengthen the operation and the stall.
    for (int w = 1; w < 4; w++) begin
      alu(6);
      do_ins(C_RMW, O_FLIP, 32'h8000_0004, 5'(w), 32'h0, w);
      do_ins(C_LD, O_CLR, 32'd4, 5'd0, 32'h0, 0);
    end

    // Constrained random mix.
    for (int k = 0; k < 500; k++) begin
      logic [1:0] c, o;
      logic [31:0] a;
      c = 2'($urandom % 4);
      o = 2'($urandom % 4);
      a = ($urandom % 3 == 0) ? (32'h8000_0000 | ($urandom % 16)) : 32'($urandom % 64);
      do_ins(c, o, a, 5'($urandom % 32), $urandom, int'($urandom % 3));
    end

    // Final readback of both regions.
    alu(12);
    for (int i = 0; i < 64; i++) do_ins(C_LD, O_CLR, 32'(i), 5'd0, 32'h0, 0);
    for (int i = 0; i < 16; i++) check(dev_mem[i] == eb[i], "R5 bus word", dev_mem[i], eb[i]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule